// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block owns the SDRAM command bus from the release of reset until the memory is ready for normal traffic. It first holds off for a programmable power-on interval. It then issues one all-bank precharge, eight auto-refresh commands and one mode-register write, in that order. A NOP goes out on every cycle between commands. The number of idle cycles after the precharge and after each refresh is set by two small wait fields. The mode-register write is followed by a single idle cycle before the block reports completion.

Every output is registered, so the command code, the address word and the done flag change only on a clock edge, apart from the asynchronous reset. If the reset pulse already covers the device's power-on requirement, the power-on count can be set to zero and the precharge follows almost at once. A start pulse given after completion runs the whole sequence again.

Top module: `sdram_init_seq`

## Requirements
- R1: While `rst_n` is low, `cmd_o` is NOP, `addr_o` is zero and `done_o` is low, and this takes effect without a clock edge. Command encoding on `cmd_o`: 0 = NOP, 1 = all-bank precharge (PALL), 2 = auto-refresh (REF), 3 = mode-register write (MRS).
- R2: With a power-on count W on `pwr_wait_i`, PALL is the first command. It appears on the (W+2)-th rising edge after reset release, so W = 0 gives the earliest start. During PALL, `addr_o` has only bit `AP_BIT` (bit 10 by default) set.
- R3: Exactly eight REF commands are issued. The first REF is preceded by `trp_sel_i`+1 NOP cycles after PALL.
- R4: Between consecutive REFs, and between the eighth REF and MRS, there are `trc_sel_i`+1 NOP cycles.
- R5: MRS is the last command, and `addr_o` carries `mode_val_i` during MRS. MRS is followed by exactly one NOP cycle with `done_o` still low.
- R6: On every NOP cycle `addr_o` is all zeros.
- R7: `done_o` rises on the edge after the post-MRS idle cycle and then stays high with NOP on `cmd_o` until reset or an accepted start.
- R8: `start_i` has no effect while the sequence is in progress: the command schedule is unchanged.
- R9: `start_i` sampled high while `done_o` is high clears `done_o` on that edge. The full sequence then reruns with the same timing as R2 to R7, counted from that edge.
- R10: Asserting reset in the middle of the sequence aborts it at once. On release the sequence restarts from the power-on wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; the sequence starts on release |
| start_i | input | 1 | Rerun request, honoured only after completion |
| trp_sel_i | input | 2 | Precharge-to-refresh wait field (idle cycles = value + 1) |
| trc_sel_i | input | 2 | Refresh-to-next-command wait field (idle cycles = value + 1) |
| pwr_wait_i | input | PWR_W (16) | Power-on wait count, sampled at sequence start |
| mode_val_i | input | ADDR_W (13) | Word placed on the address bus during MRS |
| cmd_o | output | 2 | Registered command code |
| addr_o | output | ADDR_W (13) | Registered SDRAM address bus |
| done_o | output | 1 | Initialization complete |

## Verification
The bench builds the block with its default parameters: a 16-bit power-on counter, a 13-bit address with the precharge-all bit at position 10, eight refreshes and one post-MRS idle cycle. Its vector table covers every encoding of both wait fields and power-on counts from 0 to 300, so both the shortest path out of reset and a long multi-bit countdown are exercised. A mode word with bit 10 set shows that the precharge-all flag and the mode value reach the bus only in their own cycles.

// File: rtl/sdinit_pkg.sv
package sdinit_pkg;

    typedef enum logic [1:0] {
        CMD_NOP  = 2'd0,
        CMD_PALL = 2'd1,
        CMD_REF  = 2'd2,
        CMD_MRS  = 2'd3
    } sd_cmd_e;

    typedef enum logic [2:0] {
        ST_LOAD,
        ST_PWR,
        ST_GAP_RP,
        ST_REF,
        ST_GAP_RC,
        ST_MRS,
        ST_GAP_MW,
        ST_DONE
    } seq_st_e;

endpackage

// File: rtl/sdinit_downcnt.sv
module sdinit_downcnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    input  logic         dec_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = val_i;
        end else if (dec_i && (cnt_q != '0)) begin
            cnt_d = cnt_q - W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sdinit_cmd_drv.sv
module sdinit_cmd_drv
    import sdinit_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int AP_BIT = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  sd_cmd_e           cmd_i,
    input  logic [ADDR_W-1:0] mode_i,
    input  logic              done_i,
    output logic [1:0]        cmd_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              done_o
);
    localparam logic [ADDR_W-1:0] ALL_BANKS = ADDR_W'(1) << AP_BIT;

    typedef struct packed {
        sd_cmd_e           cmd;
        logic [ADDR_W-1:0] addr;
        logic              done;
    } bus_t;

    bus_t bus_d, bus_q;

    always_comb begin
        bus_d.cmd  = cmd_i;
        bus_d.done = done_i;
        case (cmd_i)
            CMD_PALL: bus_d.addr = ALL_BANKS;
            CMD_MRS:  bus_d.addr = mode_i;
            default:  bus_d.addr = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_q.cmd  <= CMD_NOP;
            bus_q.addr <= '0;
            bus_q.done <= 1'b0;
        end else begin
            bus_q <= bus_d;
        end
    end

    assign cmd_o  = bus_q.cmd;
    assign addr_o = bus_q.addr;
    assign done_o = bus_q.done;
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
    import sdinit_pkg::*;
#(
    parameter int PWR_W    = 16,
    parameter int ADDR_W   = 13,
    parameter int AP_BIT   = 10,
    parameter int GAP_W    = 2,
    parameter int NUM_REF  = 8,
    parameter int MRS_IDLE = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [GAP_W-1:0]  trp_sel_i,
    input  logic [GAP_W-1:0]  trc_sel_i,
    input  logic [PWR_W-1:0]  pwr_wait_i,
    input  logic [ADDR_W-1:0] mode_val_i,
    output logic [1:0]        cmd_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              done_o
);
    localparam int REF_W = $clog2(NUM_REF + 1);
    localparam logic [REF_W-1:0] REF_LAST = REF_W'(NUM_REF);
    localparam logic [GAP_W-1:0] MW_GAP   = GAP_W'(MRS_IDLE - 1);

    typedef struct packed {
        seq_st_e          st;
        logic [REF_W-1:0] refs;
    } seq_t;

    seq_t             seq_d, seq_q;
    logic             pwr_load, pwr_dec, pwr_zero;
    logic             gap_load, gap_dec, gap_zero;
    logic [GAP_W-1:0] gap_val;
    sd_cmd_e          cmd_n;
    logic             done_n;

    always_comb begin
        seq_d    = seq_q;
        pwr_load = 1'b0;
        pwr_dec  = 1'b0;
        gap_load = 1'b0;
        gap_dec  = 1'b0;
        gap_val  = '0;
        cmd_n    = CMD_NOP;
        done_n   = 1'b0;
        case (seq_q.st)
            ST_LOAD: begin
                pwr_load   = 1'b1;
                seq_d.refs = '0;
                seq_d.st   = ST_PWR;
            end
            ST_PWR: begin
                if (pwr_zero) begin
                    cmd_n    = CMD_PALL;
                    gap_load = 1'b1;
                    gap_val  = trp_sel_i;
                    seq_d.st = ST_GAP_RP;
                end else begin
                    pwr_dec = 1'b1;
                end
            end
            ST_GAP_RP: begin
                if (gap_zero) seq_d.st = ST_REF;
                else          gap_dec  = 1'b1;
            end
            ST_REF: begin
                cmd_n      = CMD_REF;
                seq_d.refs = seq_q.refs + REF_W'(1);
                gap_load   = 1'b1;
                gap_val    = trc_sel_i;
                seq_d.st   = ST_GAP_RC;
            end
            ST_GAP_RC: begin
                if (gap_zero) begin
                    seq_d.st = (seq_q.refs == REF_LAST) ? ST_MRS : ST_REF;
                end else begin
                    gap_dec = 1'b1;
                end
            end
            ST_MRS: begin
                cmd_n    = CMD_MRS;
                gap_load = 1'b1;
                gap_val  = MW_GAP;
                seq_d.st = ST_GAP_MW;
            end
            ST_GAP_MW: begin
                if (gap_zero) seq_d.st = ST_DONE;
                else          gap_dec  = 1'b1;
            end
            ST_DONE: begin
                if (start_i) begin
                    seq_d.st = ST_LOAD;
                end else begin
                    done_n = 1'b1;
                end
            end
            default: seq_d.st = ST_LOAD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.st   <= ST_LOAD;
            seq_q.refs <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    sdinit_downcnt #(.W(PWR_W)) u_pwr_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (pwr_load),
        .val_i  (pwr_wait_i),
        .dec_i  (pwr_dec),
        .zero_o (pwr_zero)
    );

    sdinit_downcnt #(.W(GAP_W)) u_gap_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (gap_load),
        .val_i  (gap_val),
        .dec_i  (gap_dec),
        .zero_o (gap_zero)
    );

    sdinit_cmd_drv #(.ADDR_W(ADDR_W), .AP_BIT(AP_BIT)) u_drv (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmd_i  (cmd_n),
        .mode_i (mode_val_i),
        .done_i (done_n),
        .cmd_o  (cmd_o),
        .addr_o (addr_o),
        .done_o (done_o)
    );
endmodule

// File: rtl/sdram_init_seq_chk.sv
module sdram_init_seq_chk #(
    parameter int ADDR_W = 13,
    parameter int AP_BIT = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [ADDR_W-1:0] mode_val_i,
    input logic [1:0]        cmd_o,
    input logic [ADDR_W-1:0] addr_o,
    input logic              done_o
);
    localparam logic [ADDR_W-1:0] AP_MASK = ADDR_W'(1) << AP_BIT;

    a_r2_pall_all_banks: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == 2'd1) |-> (addr_o == AP_MASK));

    a_r4_idle_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o != 2'd0) |=> (cmd_o == 2'd0));

    a_r5_mrs_word: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == 2'd3) |-> (addr_o == $past(mode_val_i)));

    a_r5_mrs_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == 2'd3) |=> ((cmd_o == 2'd0) && !done_o));

    a_r6_nop_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == 2'd0) |-> (addr_o == '0));

    a_r7_done_nop: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (cmd_o == 2'd0));

    a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o);

    a_r9_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && start_i) |=> !done_o);
endmodule

bind sdram_init_seq sdram_init_seq_chk #(.ADDR_W(ADDR_W), .AP_BIT(AP_BIT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .mode_val_i (mode_val_i),
    .cmd_o      (cmd_o),
    .addr_o     (addr_o),
    .done_o     (done_o)
);

// File: tb/sdram_init_seq_test.sv
module sdram_init_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  trp = 2'd0;
    logic [1:0]  trc = 2'd0;
    logic [15:0] pwr = 16'd0;
    logic [12:0] mode = 13'd0;
    logic [1:0]  cmd_o;
    logic [12:0] addr_o;
    logic        done_o;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    sdram_init_seq uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .trp_sel_i  (trp),
        .trc_sel_i  (trc),
        .pwr_wait_i (pwr),
        .mode_val_i (mode),
        .cmd_o      (cmd_o),
        .addr_o     (addr_o),
        .done_o     (done_o)
    );

    // vector: {power-on count, trp field, trc field, mode word}
    localparam int NV = 6;
    localparam logic [32:0] VECS [NV] = '{
        {16'd0,   2'd0, 2'd0, 13'h0033},
        {16'd3,   2'd3, 2'd3, 13'h1FFF},
        {16'd5,   2'd1, 2'd2, 13'h0400},
        {16'd0,   2'd2, 2'd0, 13'h0A5A},
        {16'd300, 2'd0, 2'd3, 13'h0001},
        {16'd1,   2'd3, 2'd1, 13'h1555}
    };

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish (actual hung, expected completion)");
        summary();
        $finish;
    end

    task automatic check(string tag, string ctx, logic [1:0] ec, logic [12:0] ea, logic ed);
        n_chk++;
        if (cmd_o !== ec || addr_o !== ea || done_o !== ed) begin
            n_bad++;
            $display("FAIL %s %s: actual cmd=%0d addr=%h done=%b, expected cmd=%0d addr=%h done=%b",
                     tag, ctx, cmd_o, addr_o, done_o, ec, ea, ed);
        end
    endtask

    // expected bus at the k-th edge after sequence start (R2..R7)
    task automatic expect_k(int k, output logic [1:0] ec, output logic [12:0] ea,
                            output logic ed, output string tag);
        int t0, r1, m;
        t0 = int'(pwr) + 2;
        r1 = t0 + int'(trp) + 2;
        m  = r1 + 8 * (int'(trc) + 2);
        ec = 2'd0; ea = '0; ed = (k >= m + 2);
        tag = ed ? "R7" : "R6";
        if (k == t0) begin
            ec = 2'd1; ea = 13'h0400; tag = "R2";
        end else if (k == m) begin
            ec = 2'd3; ea = mode; tag = "R5";
        end else if (k >= r1 && k < m && ((k - r1) % (int'(trc) + 2)) == 0) begin
            ec = 2'd2; tag = "R3";
        end else if (k > t0 && k < r1) begin
            tag = "R3";
        end else if (k > r1 && k < m) begin
            tag = "R4";
        end else if (k == m + 1) begin
            tag = "R5";
        end
    endtask

    task automatic run_seq(string ctx, bit poke);
        int m;
        logic [1:0] ec; logic [12:0] ea; logic ed; string tag;
        m = int'(pwr) + 2 + int'(trp) + 2 + 8 * (int'(trc) + 2);
        for (int k = 1; k <= m + 6; k++) begin
            @(posedge clk);
            @(negedge clk);
            expect_k(k, ec, ea, ed, tag);
            check(tag, ctx, ec, ea, ed);
            if (poke && k == int'(pwr) + 4) start_i = 1'b1;   // R8: start while busy
            if (poke && k == int'(pwr) + 9) start_i = 1'b0;
        end
    endtask

    task automatic load_vec(int i);
        pwr  = VECS[i][32:17];
        trp  = VECS[i][16:15];
        trc  = VECS[i][14:13];
        mode = VECS[i][12:0];
    endtask

    task automatic reset_and_release();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1", "in reset", 2'd0, 13'h0, 1'b0);
        rst_n = 1'b1;
    endtask

    initial begin
        // table walk: all wait encodings, several power-on counts
        for (int i = 0; i < NV; i++) begin
            load_vec(i);
            reset_and_release();
            run_seq($sformatf("vector %0d", i), 1'b0);
        end

        // R8: start held high mid-sequence leaves the schedule unchanged
        load_vec(2);
        reset_and_release();
        run_seq("R8 start while busy", 1'b1);

        // R9: restart after completion
        @(negedge clk);
        start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        check("R9", "done cleared on accept", 2'd0, 13'h0, 1'b0);
        trp = 2'd2; trc = 2'd1; mode = 13'h0777;
        run_seq("R9 rerun", 1'b0);

        // R10: reset in the middle of the sequence
        load_vec(1);
        reset_and_release();
        repeat (int'(pwr) + 8) @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R10", "async abort", 2'd0, 13'h0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        run_seq("R10 after abort", 1'b0);

        // R1: reset from the done state
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1", "reset clears done", 2'd0, 13'h0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        summary();
        $finish;
    end
endmodule